// File: doc/BRIEF.md
# Quadword Stream-to-Memory DMA Channel

This block is one inbound DMA channel. It takes 128-bit quadwords from a streaming source and writes each one to memory. Software programs three registers: a destination byte address, a count of quadwords still to move, and a control word whose start bit arms the channel. Arming the channel does not move data by itself. Each quadword moves only when the source presents it on a valid/ready handshake. The channel raises ready only while it is armed and quadwords remain. Each accepted quadword appears on the memory write port one cycle later. The address then steps by 16 bytes and the count drops by one.

The top bit of the programmed address chooses the target. When it is set, the write goes to a small scratchpad and the address wraps within a 14-bit byte window. When it is clear, the write goes to main RAM and the address wraps within a 25-bit window. When the count reaches zero, the channel disarms itself and sends a one-cycle completion pulse to the interrupt unit. Arming the channel with a count of zero produces that pulse at once.

Register slots are 16 bytes apart: control at offset 0x00, address at 0x10, count at 0x20. Only the first 32-bit word of each slot is live.

Top module: `qw_dma_chan`

## Requirements
- R1: After reset, the control, address and count registers read 0, src_ready is low, and mem_we and done_pulse are low.
- R2: Bit 8 of the control register (offset 0x00) is the start bit. While it is clear, src_ready stays low and no quadword is accepted, whatever the count.
- R3: A quadword accepted at a clock edge (src_valid and src_ready both high) is written at the next edge: mem_we is high for one cycle with that data. The address register (offset 0x10, low 4 bits always stored as 0) then advances by 16.
- R4: The count register (offset 0x20, 16 bits, zero-extended on read) drops by one for each accepted quadword.
- R5: The edge that accepts the last quadword clears the start bit and makes done_pulse high for exactly one cycle. src_ready is then low, so any surplus input is refused.
- R6: When address bit 31 is set, mem_sel_spr is 1 and mem_addr is the address ANDed with 0x3FFF. When bit 31 is clear, mem_sel_spr is 0 and mem_addr is the address ANDed with 0x1FFFFFF.
- R7: Writing the control register with the start bit set and a nonzero count causes no memory write until the source supplies data.
- R8: Writes to word offsets +4, +8 and +C of any slot have no effect, and reads there return 0. Reads of the unmapped slot at 0x30 also return 0.
- R9: While the start bit is set, writes to the address and count registers are ignored.
- R10: Writing the start bit while the count is zero leaves the start bit clear and gives exactly one done_pulse, one cycle after the write.
- R11: A register read returns its data on reg_rdata one cycle after reg_rd is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 6 | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| src_valid | input | 1 | Source holds a quadword |
| src_data | input | 128 | Source quadword |
| src_ready | output | 1 | Channel accepts a quadword this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_sel_spr | output | 1 | 1 selects scratchpad, 0 selects main RAM |
| mem_addr | output | 32 | Wrapped byte address of the write |
| mem_wdata | output | 128 | Quadword written |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The bench sends bursts longer than the programmed count. A channel that does not clip would emit extra memory writes, and the scoreboard would flag them as unexpected. Runs are placed so they cross the top of each region. A wrong mask, or a scratchpad select taken from the wrapped address, would show up as a wrong mem_addr or mem_sel_spr. The bench also writes the address and count while the channel is armed, writes to the dead word offsets, and arms the channel with a zero count. Any of these would corrupt read-back values, start a transfer at the wrong place, or give a missing or doubled completion pulse.

// File: rtl/qw_dma_pkg.sv
package qw_dma_pkg;
  localparam int ADDR_W    = 32;
  localparam int REG_W     = 32;
  localparam int OFF_W     = 6;
  localparam int START_BIT = 8;
  localparam int QW_BYTES  = 16;
  localparam int QW_LSB    = $clog2(QW_BYTES);

  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_ADDR  = 2'd1,
    SLOT_COUNT = 2'd2,
    SLOT_NONE  = 2'd3
  } slot_e;
endpackage

// File: rtl/qw_dma_regs.sv
module qw_dma_regs
  import qw_dma_pkg::*;
#(
  parameter int QWC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [OFF_W-1:0]  off,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              accept,
  output logic              start_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [QWC_W-1:0]  cnt_o,
  output logic              done_o
);
  logic [REG_W-1:0]  ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [QWC_W-1:0]  cnt_q;
  logic [QWC_W-1:0]  cnt_after;
  logic              live_word;
  logic              last_acc;
  slot_e             slot;

  assign slot      = slot_e'(off[5:4]);
  assign live_word = (off[3:2] == 2'b00);
  assign last_acc  = accept && (cnt_q == QWC_W'(1));
  assign cnt_after = accept ? cnt_q - QWC_W'(1) : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
      rdata  <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        addr_q <= addr_q + ADDR_W'(QW_BYTES);
        cnt_q  <= cnt_after;
      end
      if (last_acc) begin
        ctrl_q[START_BIT] <= 1'b0;
        done_o            <= 1'b1;
      end
      if (wr && live_word) begin
        unique case (slot)
          SLOT_CTRL: begin
            ctrl_q <= wdata;
            if (wdata[START_BIT] && cnt_after == '0) begin
              ctrl_q[START_BIT] <= 1'b0;
              done_o            <= 1'b1;
            end
          end
          SLOT_ADDR: if (!ctrl_q[START_BIT])
            addr_q <= {wdata[ADDR_W-1:QW_LSB], {QW_LSB{1'b0}}};
          SLOT_COUNT: if (!ctrl_q[START_BIT])
            cnt_q <= wdata[QWC_W-1:0];
          default: ;
        endcase
      end
      if (rd) begin
        rdata <= '0;
        if (live_word) begin
          unique case (slot)
            SLOT_CTRL:  rdata <= ctrl_q;
            SLOT_ADDR:  rdata <= addr_q;
            SLOT_COUNT: rdata <= REG_W'(cnt_q);
            default:    rdata <= '0;
          endcase
        end
      end
    end
  end

  assign start_o = ctrl_q[START_BIT];
  assign addr_o  = addr_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/qw_dma_addr_map.sv
module qw_dma_addr_map
  import qw_dma_pkg::*;
#(
  parameter int SPR_AW = 14,
  parameter int RAM_AW = 25
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              spr_o,
  output logic [ADDR_W-1:0] phys_o
);
  localparam int SEL_BIT = ADDR_W - 1;

  assign spr_o = addr_i[SEL_BIT];

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b < SPR_AW && b < RAM_AW) begin : g_both
      assign phys_o[b] = addr_i[b];
    end else if (b < SPR_AW) begin : g_spr
      assign phys_o[b] = spr_o & addr_i[b];
    end else if (b < RAM_AW) begin : g_ram
      assign phys_o[b] = ~spr_o & addr_i[b];
    end else begin : g_none
      assign phys_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/qw_dma_xfer.sv
module qw_dma_xfer
  import qw_dma_pkg::*;
#(
  parameter int QWC_W  = 16,
  parameter int DATA_W = 128,
  parameter int SPR_AW = 14,
  parameter int RAM_AW = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [QWC_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              accept,
  output logic              mem_we,
  output logic              mem_sel_spr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              spr_sel;
  logic [ADDR_W-1:0] phys;

  qw_dma_addr_map #(.SPR_AW(SPR_AW), .RAM_AW(RAM_AW)) u_map (
    .addr_i (addr),
    .spr_o  (spr_sel),
    .phys_o (phys)
  );

  assign src_ready = start && (cnt != '0);
  assign accept    = src_ready && src_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we      <= 1'b0;
      mem_sel_spr <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      mem_we <= accept;
      if (accept) begin
        mem_sel_spr <= spr_sel;
        mem_addr    <= phys;
        mem_wdata   <= src_data;
      end
    end
  end
endmodule

// File: rtl/qw_dma_chan.sv
module qw_dma_chan
  import qw_dma_pkg::*;
#(
  parameter int QWC_W  = 16,
  parameter int DATA_W = 128,
  parameter int SPR_AW = 14,
  parameter int RAM_AW = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_off,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              mem_we,
  output logic              mem_sel_spr,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done_pulse
);
  logic              start;
  logic              accept;
  logic [ADDR_W-1:0] addr;
  logic [QWC_W-1:0]  cnt;

  qw_dma_regs #(.QWC_W(QWC_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .off     (reg_off),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .accept  (accept),
    .start_o (start),
    .addr_o  (addr),
    .cnt_o   (cnt),
    .done_o  (done_pulse)
  );

  qw_dma_xfer #(
    .QWC_W(QWC_W), .DATA_W(DATA_W), .SPR_AW(SPR_AW), .RAM_AW(RAM_AW)
  ) u_xfer (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cnt         (cnt),
    .addr        (addr),
    .src_valid   (src_valid),
    .src_data    (src_data),
    .src_ready   (src_ready),
    .accept      (accept),
    .mem_we      (mem_we),
    .mem_sel_spr (mem_sel_spr),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );
endmodule

// File: rtl/qw_dma_chan_chk.sv
module qw_dma_chan_chk #(
  parameter int SPR_AW = 14,
  parameter int RAM_AW = 25
) (
  input logic        clk,
  input logic        rst,
  input logic        src_valid,
  input logic        src_ready,
  input logic        mem_we,
  input logic        mem_sel_spr,
  input logic [31:0] mem_addr,
  input logic        done_pulse
);
  assert_write_follows_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (src_valid && src_ready) |=> mem_we);

  assert_no_write_without_accept_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(src_valid && src_ready));

  assert_qw_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[3:0] == 4'h0));

  assert_done_blocks_input_R5: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> !src_ready);

  assert_spr_window_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_sel_spr) |-> ((mem_addr >> SPR_AW) == 32'd0));

  assert_ram_window_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_sel_spr) |-> ((mem_addr >> RAM_AW) == 32'd0));

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_we && !done_pulse && !src_ready));
endmodule

bind qw_dma_chan qw_dma_chan_chk #(.SPR_AW(SPR_AW), .RAM_AW(RAM_AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_valid   (src_valid),
  .src_ready   (src_ready),
  .mem_we      (mem_we),
  .mem_sel_spr (mem_sel_spr),
  .mem_addr    (mem_addr),
  .done_pulse  (done_pulse)
);

// File: tb/qw_dma_chan_bench.sv
module qw_dma_chan_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]   reg_off = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         src_valid = 1'b0;
  logic [127:0] src_data = '0;
  logic         src_ready, mem_we, mem_sel_spr, done_pulse;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;

  typedef struct { logic sel; logic [31:0] addr; logic [127:0] data; } wr_item_t;
  wr_item_t exp_q[$];

  int checks = 0, fails = 0, done_seen = 0;
  logic [31:0] m_addr;
  int          m_cnt;
  logic        m_start;

  always #4 clk = ~clk;

  qw_dma_chan u_qw_dma_chan (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .mem_we(mem_we),
    .mem_sel_spr(mem_sel_spr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done_pulse(done_pulse)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every memory write, counts completion pulses.
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected write", {mem_sel_spr, mem_addr}, 0);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        check(mem_sel_spr == e.sel, "R6 select", mem_sel_spr, e.sel);
        check(mem_addr == e.addr, "R3 address", mem_addr, e.addr);
        check(mem_wdata == e.data, "R3 data", mem_wdata, e.data);
      end
    end
    if (!rst && done_pulse) done_seen++;
  end

  task automatic reg_write(input logic [5:0] off, input logic [31:0] d);
    reg_wr = 1'b1; reg_off = off; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] off, output logic [31:0] d);
    reg_rd = 1'b1; reg_off = off;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic expect_reg(input logic [5:0] off, input logic [31:0] exp, input string req);
    logic [31:0] d;
    reg_read(off, d);
    check(d == exp, req, d, exp);
  endtask

  function automatic logic [31:0] wrap(input logic [31:0] a);
    return a[31] ? (a & 32'h0000_3FFF) : (a & 32'h01FF_FFFF);
  endfunction

  // Driver: offers n quadwords back to back, pushes expected writes.
  task automatic stream(input int n, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      bit exp_rdy, took;
      src_valid = 1'b1;
      src_data  = {$urandom, $urandom, $urandom, $urandom};
      exp_rdy   = m_start && (m_cnt != 0);
      check(src_ready == exp_rdy, "R5 ready", src_ready, exp_rdy);
      took = src_ready;
      if (took) begin
        wr_item_t it;
        it.sel = m_addr[31]; it.addr = wrap(m_addr); it.data = src_data;
        exp_q.push_back(it);
        m_addr = m_addr + 32'd16; m_cnt--; acc++;
      end
      @(posedge clk); #1;
      if (took && m_cnt == 0) begin
        m_start = 1'b0;
        check(done_pulse == 1'b1, "R5 done timing", done_pulse, 1);
      end
    end
    src_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic arm(input logic [31:0] a, input int c);
    reg_write(6'h10, a);
    reg_write(6'h20, c);
    m_addr = {a[31:4], 4'h0}; m_cnt = c;
    reg_write(6'h00, 32'h100);
    m_start = (c != 0);
  endtask

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int acc, d0;
    logic [31:0] d;
    m_addr = 0; m_cnt = 0; m_start = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;

    // R1 reset state
    check(src_ready == 0 && mem_we == 0 && done_pulse == 0, "R1 outputs", src_ready, 0);
    expect_reg(6'h00, 0, "R1 ctrl");
    expect_reg(6'h10, 0, "R1 addr");
    expect_reg(6'h20, 0, "R1 count");

    // R2 start bit clear blocks transfer; R11 read latency
    reg_write(6'h10, 32'h0000_1000);
    reg_write(6'h20, 3);
    reg_write(6'h00, 32'h0000_0001);
    m_addr = 32'h1000; m_cnt = 3; m_start = 0;
    reg_rd = 1'b1; reg_off = 6'h20;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    check(reg_rdata == 3, "R11 read data next cycle", reg_rdata, 3);
    stream(2, acc);
    check(acc == 0, "R2 no accept", acc, 0);
    expect_reg(6'h20, 3, "R2 count held");

    // R7 arming moves nothing
    reg_write(6'h00, 32'h100); m_start = 1;
    repeat (4) @(posedge clk); #1;
    check(exp_q.size() == 0, "R7 no data", exp_q.size(), 0);
    expect_reg(6'h20, 3, "R7 count held");
    expect_reg(6'h00, 32'h100, "R2 start reads set");

    // R3/R4 one quadword then a clipped burst (R5)
    d0 = done_seen;
    stream(1, acc);
    expect_reg(6'h20, 2, "R4 count after one");
    expect_reg(6'h10, 32'h1010, "R3 address step");
    stream(5, acc);
    check(acc == 2, "R5 burst clipped", acc, 2);
    expect_reg(6'h00, 0, "R5 start cleared");
    expect_reg(6'h20, 0, "R4 count zero");
    check(done_seen - d0 == 1, "R5 one pulse", done_seen - d0, 1);

    // R6 RAM wrap
    arm(32'h01FF_FFF0, 2);
    stream(3, acc);
    check(acc == 2, "R6 ram run", acc, 2);
    // R6 scratchpad wrap
    arm(32'h8000_3FF0, 3);
    stream(3, acc);
    check(acc == 3, "R6 spr run", acc, 3);

    // R9 writes while armed ignored
    arm(32'h0000_2000, 4);
    reg_write(6'h10, 32'h0000_5000);
    reg_write(6'h20, 9);
    expect_reg(6'h10, 32'h2000, "R9 addr kept");
    expect_reg(6'h20, 4, "R9 count kept");
    d0 = done_seen;
    stream(6, acc);
    check(acc == 4, "R9 count used", acc, 4);
    check(done_seen - d0 == 1, "R9 done", done_seen - d0, 1);

    // R8 dead word offsets
    reg_write(6'h10, 32'h0000_7000);
    reg_write(6'h14, 32'h0000_ABC0);
    reg_write(6'h2C, 32'h0000_0077);
    d0 = done_seen;
    reg_write(6'h08, 32'h100);
    repeat (2) @(posedge clk); #1;
    expect_reg(6'h10, 32'h7000, "R8 addr untouched");
    expect_reg(6'h20, 0, "R8 count untouched");
    expect_reg(6'h00, 0, "R8 ctrl untouched");
    check(done_seen == d0, "R8 no pulse", done_seen - d0, 0);
    expect_reg(6'h14, 0, "R8 read +4");
    expect_reg(6'h28, 0, "R8 read +8");
    expect_reg(6'h0C, 0, "R8 read +C");
    expect_reg(6'h30, 0, "R8 unmapped slot");

    // R10 start with zero count
    d0 = done_seen;
    reg_write(6'h00, 32'h100);
    check(done_pulse == 1'b1, "R10 pulse timing", done_pulse, 1);
    repeat (3) @(posedge clk); #1;
    check(done_seen - d0 == 1, "R10 single pulse", done_seen - d0, 1);
    check(src_ready == 1'b0, "R10 ready low", src_ready, 0);
    expect_reg(6'h00, 0, "R10 start clear");

    repeat (3) @(posedge clk); #1;
    check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule